// File: doc/BRIEF.md
# Raw IF Sample Snapshot Buffer

This block records a contiguous window of raw converter samples from two reception paths so that software can later pull them off-chip for offline spectral analysis, interference study or spoofing checks. On every sample clock it takes the 4-bit in-phase and quadrature samples of the upper-band complex path and the 4-bit real sample of the lower-band path, packs all three into one 12-bit word, and on a software trigger writes a run of consecutive words into a RAM that lives outside the block.

That RAM is shared with the acquisition engine. While the engine holds it (`acq_own` high) every request to this block is refused and flagged. After a capture completes, a readout request walks the stored words from address zero upward and presents them one at a time on a valid/ready stream. A serial port adapter can consume this stream.

The capture length is programmable. A length of zero, or one above the buffer depth, selects the full depth.

Top module: `snap_buffer`

## Requirements
- R1: After reset, `cap_busy`, `cap_done`, `req_rej`, `rd_valid`, `rd_last`, `mem_en` and `mem_we` are all 0.
- R2: Each stored word is `{l1_i, l1_q, l5_r}`: the I sample in bits 11:8, Q in bits 7:4 and the real sample in bits 3:0. Word k holds the samples present at the clock edge that accepts the start, plus k edges.
- R3: An accepted capture of length N (1 ≤ N ≤ 81920) performs exactly N writes, to addresses 0, 1, … N-1 on consecutive cycles.
- R4: A requested length of 0, or one greater than 81920, results in exactly 81920 writes. No write address reaches 81920.
- R5: `cap_busy` is high while words are written. `cap_done` rises on the edge after the last write and stays high until the next accepted capture start.
- R6: A capture start while `acq_own` is high is refused. `req_rej` pulses high for one cycle after it, no write occurs, and `cap_done` keeps its value.
- R7: A capture start while a capture or a readout is running is refused with a `req_rej` pulse and does not change the running operation's length or write count. Capture and readout are never active together.
- R8: Readout presents words in address order from 0, advancing by one word per valid/ready handshake. While `rd_valid` is high and `rd_ready` is low, `rd_data` and `rd_valid` hold.
- R9: `rd_last` is high together with `rd_valid` exactly on the final captured word. After that word's handshake, `rd_valid` falls.
- R10: A readout start is accepted only when a capture has completed (`cap_done` high). Otherwise it is refused with a `req_rej` pulse and no word appears.
- R11: When capture start and readout start arrive in the same cycle, the capture is accepted and the readout is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low reset |
| l1_i | input | 4 | Upper-band in-phase sample |
| l1_q | input | 4 | Upper-band quadrature sample |
| l5_r | input | 4 | Lower-band real sample |
| acq_own | input | 1 | Acquisition engine currently holds the shared RAM |
| cap_start | input | 1 | Capture request pulse |
| cap_len | input | 17 | Requested number of sample words |
| cap_busy | output | 1 | Capture in progress |
| cap_done | output | 1 | A capture has completed |
| req_rej | output | 1 | One-cycle pulse: the previous cycle's request was refused |
| rd_start | input | 1 | Readout request pulse |
| rd_valid | output | 1 | Readout word available |
| rd_ready | input | 1 | Consumer accepts the word |
| rd_data | output | 12 | Readout word |
| rd_last | output | 1 | Current word is the final captured one |
| mem_en | output | 1 | Shared RAM access enable |
| mem_we | output | 1 | Shared RAM write enable |
| mem_addr | output | 17 | Shared RAM address |
| mem_wdata | output | 12 | Shared RAM write data |
| mem_rdata | input | 12 | Shared RAM read data, one cycle after a read |

## Verification
The following properties are checked on every cycle:
- Write addresses step by one within a capture and never reach the depth.
- Done rises only right after a write.
- Capture and readout never overlap.
- A start seen while acquisition owns the RAM is always followed by a refusal.
- A stalled readout word stays put.
- The last flag and the valid flag stay consistent.

Only the directed scenarios can show the rest. These are the exact packed content and its sample alignment, the write counts for exact and clamped lengths, the cycle on which done rises, and that refused requests leave the running capture and the done flag untouched.

// File: rtl/snap_pkg.sv
package snap_pkg;

    // Readout walk states: issue a RAM read, let the RAM answer, present the word.
    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_FETCH = 2'd1,
        RD_WAIT  = 2'd2,
        RD_SHOW  = 2'd3
    } rd_state_e;

    // Number of sample lanes packed into one stored word (I, Q, real).
    localparam int LANES = 3;

endpackage

// File: rtl/snap_sample_pack.sv
module snap_sample_pack #(
    parameter int SAMP_W = 4,
    parameter int LANES  = 3,
    localparam int WORD_W = SAMP_W * LANES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SAMP_W-1:0]     lane_in [LANES],
    output logic [WORD_W-1:0]     word_q
);

    logic [WORD_W-1:0] word_d;

    // Lane 0 lands in the most significant slot, the last lane in the least.
    always_comb begin
        word_d = '0;
        for (int j = 0; j < LANES; j++) begin
            word_d[(LANES - j) * SAMP_W - 1 -: SAMP_W] = lane_in[j];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

endmodule

// File: rtl/snap_capture_ctrl.sv
module snap_capture_ctrl #(
    parameter int MAX_DEPTH = 81920,
    localparam int ADDR_W = $clog2(MAX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_acc,
    input  logic [ADDR_W-1:0] req_len,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] cap_len,
    output logic              done
);

    localparam logic [ADDR_W-1:0] MAX_L = ADDR_W'(MAX_DEPTH);
    localparam logic [ADDR_W-1:0] ONE   = ADDR_W'(1);

    typedef struct packed {
        logic              act;
        logic              done;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] len;
    } cap_st_t;

    cap_st_t cs_q, cs_d;
    logic [ADDR_W-1:0] len_clamped;

    always_comb begin
        len_clamped = (req_len == '0 || req_len > MAX_L) ? MAX_L : req_len;
        cs_d = cs_q;
        if (start_acc) begin
            cs_d.act  = 1'b1;
            cs_d.done = 1'b0;
            cs_d.addr = '0;
            cs_d.len  = len_clamped;
        end else if (cs_q.act) begin
            if (cs_q.addr == cs_q.len - ONE) begin
                cs_d.act  = 1'b0;
                cs_d.done = 1'b1;
            end else begin
                cs_d.addr = cs_q.addr + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    assign wr_en   = cs_q.act;
    assign wr_addr = cs_q.addr;
    assign cap_len = cs_q.len;
    assign done    = cs_q.done;

    // R3
    wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && $past(wr_en) |-> wr_addr == $past(wr_addr) + ONE);

    // R4
    wr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_addr < MAX_L);

    // R5
    done_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(wr_en));

endmodule

// File: rtl/snap_readout_ctrl.sv
module snap_readout_ctrl
    import snap_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_acc,
    input  logic [ADDR_W-1:0] word_cnt,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_last,
    output logic              active
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    typedef struct packed {
        rd_state_e         st;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } rd_st_t;

    rd_st_t rs_q, rs_d;
    logic   at_end;

    always_comb begin
        rs_d   = rs_q;
        rd_en  = 1'b0;
        at_end = (rs_q.addr == word_cnt - ONE);
        case (rs_q.st)
            RD_IDLE: begin
                if (start_acc) begin
                    rs_d.st   = RD_FETCH;
                    rs_d.addr = '0;
                end
            end
            RD_FETCH: begin
                rd_en   = 1'b1;
                rs_d.st = RD_WAIT;
            end
            RD_WAIT: begin
                rs_d.data = mem_rdata;
                rs_d.st   = RD_SHOW;
            end
            RD_SHOW: begin
                if (rd_ready) begin
                    if (at_end) begin
                        rs_d.st = RD_IDLE;
                    end else begin
                        rs_d.addr = rs_q.addr + ONE;
                        rs_d.st   = RD_FETCH;
                    end
                end
            end
            default: rs_d.st = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '{st: RD_IDLE, addr: '0, data: '0};
        else        rs_q <= rs_d;
    end

    assign rd_addr  = rs_q.addr;
    assign rd_valid = (rs_q.st == RD_SHOW);
    assign rd_data  = rs_q.data;
    assign rd_last  = rd_valid && at_end;
    assign active   = (rs_q.st != RD_IDLE);

    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

    // R9
    rd_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last && rd_ready |=> !rd_valid);

endmodule

// File: rtl/snap_buffer.sv
module snap_buffer
    import snap_pkg::*;
#(
    parameter int SAMP_W    = 4,
    parameter int MAX_DEPTH = 81920,
    localparam int ADDR_W = $clog2(MAX_DEPTH + 1),
    localparam int WORD_W = SAMP_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SAMP_W-1:0] l1_i,
    input  logic [SAMP_W-1:0] l1_q,
    input  logic [SAMP_W-1:0] l5_r,
    input  logic              acq_own,
    input  logic              cap_start,
    input  logic [ADDR_W-1:0] cap_len,
    output logic              cap_busy,
    output logic              cap_done,
    output logic              req_rej,
    input  logic              rd_start,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_last,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata
);

    logic [SAMP_W-1:0] lanes [LANES];
    logic [WORD_W-1:0] word_q;
    logic              cap_acc, rd_acc, cap_wr, rd_rd, rd_act, done_w;
    logic [ADDR_W-1:0] wr_addr, rd_addr, stored_len;

    typedef struct packed {
        logic rej;
    } top_st_t;

    top_st_t ts_q, ts_d;

    assign lanes[0] = l1_i;
    assign lanes[1] = l1_q;
    assign lanes[2] = l5_r;

    snap_sample_pack #(
        .SAMP_W (SAMP_W),
        .LANES  (LANES)
    ) u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .lane_in (lanes),
        .word_q  (word_q)
    );

    // Arbitration of requests against the shared RAM and the running operation.
    always_comb begin
        cap_acc  = cap_start && !acq_own && !cap_wr && !rd_act;
        rd_acc   = rd_start && !cap_start && !acq_own && !cap_wr && !rd_act && done_w;
        ts_d.rej = (cap_start && !cap_acc) || (rd_start && !rd_acc);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ts_q <= '0;
        else        ts_q <= ts_d;
    end

    snap_capture_ctrl #(
        .MAX_DEPTH (MAX_DEPTH)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_acc (cap_acc),
        .req_len   (cap_len),
        .wr_en     (cap_wr),
        .wr_addr   (wr_addr),
        .cap_len   (stored_len),
        .done      (done_w)
    );

    snap_readout_ctrl #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_acc (rd_acc),
        .word_cnt  (stored_len),
        .rd_en     (rd_rd),
        .rd_addr   (rd_addr),
        .mem_rdata (mem_rdata),
        .rd_valid  (rd_valid),
        .rd_ready  (rd_ready),
        .rd_data   (rd_data),
        .rd_last   (rd_last),
        .active    (rd_act)
    );

    assign mem_en    = cap_wr || rd_rd;
    assign mem_we    = cap_wr;
    assign mem_addr  = cap_wr ? wr_addr : rd_addr;
    assign mem_wdata = word_q;
    assign cap_busy  = cap_wr;
    assign cap_done  = done_w;
    assign req_rej   = ts_q.rej;

    // R7
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_wr && rd_act));

    // R6
    acq_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_start && acq_own |=> req_rej);

    // R10
    rd_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> cap_done);

endmodule

// File: tb/snap_buffer_bench.sv
module snap_buffer_bench;
    localparam int MAXD = 81920;
    localparam int AW   = 17;
    localparam int WW   = 12;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic [3:0]    l1_i, l1_q, l5_r;
    logic          acq_own = 1'b0, cap_start = 1'b0, rd_start = 1'b0, rd_ready = 1'b0;
    logic [AW-1:0] cap_len = '0;
    logic          cap_busy, cap_done, req_rej, rd_valid, rd_last, mem_en, mem_we;
    logic [WW-1:0] rd_data, mem_wdata;
    logic [WW-1:0] mem_rdata = '0;
    logic [AW-1:0] mem_addr;

    snap_buffer u_snap_buffer (
        .clk(clk), .rst_n(rst_n), .l1_i(l1_i), .l1_q(l1_q), .l5_r(l5_r),
        .acq_own(acq_own), .cap_start(cap_start), .cap_len(cap_len),
        .cap_busy(cap_busy), .cap_done(cap_done), .req_rej(req_rej),
        .rd_start(rd_start), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .rd_data(rd_data), .rd_last(rd_last), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Sample source: a free-running counter changed on falling edges.
    logic [7:0] cnt = 8'd0;
    always @(negedge clk) cnt <= cnt + 8'd1;
    assign l1_i = cnt[3:0];
    assign l1_q = cnt[7:4];
    assign l5_r = cnt[3:0] ^ cnt[7:4];

    function automatic logic [11:0] expw(input logic [7:0] c);
        return {c[3:0], c[7:4], c[3:0] ^ c[7:4]};
    endfunction

    // Shared RAM model, aliased to 128 words.
    logic [11:0] mem [128];
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr[6:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[6:0]];
        end
    end

    // Write monitor.
    logic mon_clr = 1'b0;
    int   wr_cnt = 0, seq_err = 0, exp_a = 0;
    always @(posedge clk) begin
        if (mon_clr) begin
            wr_cnt = 0; seq_err = 0; exp_a = 0;
        end else if (mem_en && mem_we) begin
            if (int'(mem_addr) != exp_a) seq_err++;
            exp_a = int'(mem_addr) + 1;
            wr_cnt++;
        end
    end

    int total = 0, bad = 0, cyc = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic clear_mon();
        mon_clr = 1'b1;
        step();
        mon_clr = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 195000 && !finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 195000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) step();
        rst_n = 1'b1;
        step();
        // R1
        chk(!cap_busy && !cap_done, "R1 busy/done", {cap_busy, cap_done}, 0);
        chk(!req_rej && !rd_valid && !rd_last, "R1 rej/valid/last", {req_rej, rd_valid, rd_last}, 0);
        chk(!mem_en && !mem_we, "R1 mem enables", {mem_en, mem_we}, 0);
    endtask

    task automatic t_read_before_capture();
        step();
        rd_start = 1'b1;
        step();
        rd_start = 1'b0;
        // R10
        chk(req_rej, "R10 refused readout flag", req_rej, 1);
        repeat (4) step();
        chk(!rd_valid, "R10 no word without capture", rd_valid, 0);
    endtask

    task automatic do_capture(input int len, input int eff, output logic [7:0] c0);
        clear_mon();
        cap_len   = AW'(len);
        cap_start = 1'b1;
        c0        = cnt;
        step();
        cap_start = 1'b0;
        repeat (eff - 1) step();
        // R5
        chk(cap_busy && !cap_done, "R5 busy on last write", {cap_busy, cap_done}, 2);
        step();
        chk(!cap_busy && cap_done, "R5 done after last write", {cap_busy, cap_done}, 1);
        // R3 R4
        chk(wr_cnt == eff, "R3/R4 write count", wr_cnt, eff);
        chk(seq_err == 0, "R3 address sequence", seq_err, 0);
    endtask

    task automatic do_read(input int n, input logic [7:0] c0);
        step();
        rd_start = 1'b1;
        step();
        rd_start = 1'b0;
        chk(!req_rej, "R10 readout accepted after done", req_rej, 0);
        for (int k = 0; k < n; k++) begin
            int t = 0;
            while (!rd_valid && t < 10) begin step(); t++; end
            // R2 R8
            chk(rd_data == expw(c0 + 8'(k)), "R2/R8 word content", rd_data, expw(c0 + 8'(k)));
            // R9
            chk(rd_last == (k == n - 1), "R9 last flag", rd_last, (k == n - 1));
            if (k % 3 == 1) begin
                logic [11:0] held = rd_data;
                step();
                // R8
                chk(rd_valid && rd_data == held, "R8 stall hold", rd_data, held);
            end
            rd_ready = 1'b1;
            step();
            rd_ready = 1'b0;
        end
        repeat (3) step();
        // R9
        chk(!rd_valid, "R9 valid drops after last", rd_valid, 0);
    endtask

    task automatic t_acq_block();
        clear_mon();
        acq_own   = 1'b1;
        cap_len   = AW'(5);
        cap_start = 1'b1;
        step();
        cap_start = 1'b0;
        // R6
        chk(req_rej && !cap_busy, "R6 refused under acquisition", {req_rej, cap_busy}, 2);
        step();
        chk(!req_rej, "R6 refusal is one pulse", req_rej, 0);
        repeat (6) step();
        chk(wr_cnt == 0, "R6 no writes", wr_cnt, 0);
        chk(cap_done, "R6 done kept", cap_done, 1);
        acq_own = 1'b0;
    endtask

    task automatic t_restart_during_capture();
        clear_mon();
        cap_len   = AW'(30);
        cap_start = 1'b1;
        step();
        cap_start = 1'b0;
        repeat (4) step();
        cap_len   = AW'(3);
        cap_start = 1'b1;
        step();
        cap_start = 1'b0;
        // R7
        chk(req_rej, "R7 restart refused", req_rej, 1);
        repeat (40) step();
        chk(wr_cnt == 30, "R7 original length kept", wr_cnt, 30);
        chk(cap_done, "R7 capture completes", cap_done, 1);
    endtask

    task automatic t_both_starts();
        clear_mon();
        cap_len   = AW'(4);
        cap_start = 1'b1;
        rd_start  = 1'b1;
        step();
        cap_start = 1'b0;
        rd_start  = 1'b0;
        // R11
        chk(cap_busy && req_rej, "R11 capture wins, readout refused", {cap_busy, req_rej}, 3);
        repeat (6) step();
        chk(wr_cnt == 4 && !rd_valid, "R11 no readout ran", wr_cnt, 4);
    endtask

    initial begin
        logic [7:0] c0;
        t_reset();
        t_read_before_capture();
        do_capture(20, 20, c0);
        do_read(20, c0);
        t_acq_block();
        t_restart_during_capture();
        do_capture(7, 7, c0);
        do_read(7, c0);
        t_both_starts();
        // R4: zero length and oversize length both clamp to full depth
        do_capture(0, MAXD, c0);
        do_capture(90000, MAXD, c0);
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule